// File: doc/BRIEF.md
# Peripheral DMA Request/Acknowledge Handshake

This block sits between one DMA channel and the peripheral that paces it. The peripheral raises a request line, which may be treated as edge-triggered or level-triggered. The block synchronizes that line and forwards it to the channel sequencer as a pending request. It then answers the peripheral with an acknowledge strobe and a transfer-end strobe that frame each memory-side write transaction.

The acknowledge opens when the channel issues its write address (write address valid, with a request pending while the handshake is idle). It closes when the write response handshake completes. In write-active mode it stays open for one more cycle after that response.

While the acknowledge is open, a level-sensed request is masked. A request that is still high therefore cannot start a second transfer before the bus cycle is finished. The transfer-end strobe marks only the final transaction of a DMA operation and is framed by the same acknowledge window.

Top module: `dma_periph_hs`

## Requirements
- R1: A synchronous active-low reset drives `ack_o`, `tend_o` and `req_pending_o` low, and they stay low on the first cycle after reset is released.
- R2: In edge mode (`level_sense_i` = 0), a 0-to-1 change of `req_i` makes `req_pending_o` high three rising clock edges after it is applied (two synchronizer stages plus the latch). A request that stays high does not raise the pending flag again.
- R3: In level mode (`level_sense_i` = 1), `req_pending_o` follows `req_i` two rising edges later while `ack_o` is low.
- R4: `ack_o` rises on the edge that samples `aw_valid_i` high while `ack_o` is low and `req_pending_o` is high. `aw_valid_i` has no effect when no request is pending.
- R5: With `wr_active_i` = 0, `ack_o` falls on the edge that samples `b_valid_i` and `b_ready_i` both high while the acknowledge window is in its data phase.
- R6: With `wr_active_i` = 1, `ack_o` remains high for exactly one extra cycle after the response handshake and then falls.
- R7: In level mode, `req_pending_o` is low whenever `ack_o` is high. A request still held high is reported again in the first cycle in which `ack_o` is low.
- R8: `tend_o` rises together with `ack_o` if and only if `last_i` was high on the starting edge.
- R9: `tend_o` is never high while `ack_o` is low, and it falls on the same edge as `ack_o`.
- R10: In edge mode, the pending flag clears on the edge where `ack_o` rises. A new rising request edge that arrives while the acknowledge is open stays latched and is reported after the acknowledge window.
- R11: A response cycle in which only one of `b_valid_i` and `b_ready_i` is high does not end the acknowledge window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Asynchronous peripheral request |
| level_sense_i | input | 1 | 1 = level-sensed request, 0 = edge-sensed request |
| wr_active_i | input | 1 | 1 = write-active mode, acknowledge held one extra cycle |
| aw_valid_i | input | 1 | Memory-side write address valid (transfer start) |
| b_valid_i | input | 1 | Memory-side write response valid |
| b_ready_i | input | 1 | Memory-side write response ready |
| last_i | input | 1 | Sequencer flag: this transfer is the final one |
| req_pending_o | output | 1 | Request forwarded to the channel sequencer |
| ack_o | output | 1 | Acknowledge to the peripheral |
| tend_o | output | 1 | Transfer-end strobe to the peripheral |

## Verification
A corrupted handshake state shows at `ack_o` on the very next edge after a start or response sample. It appears as a window that opens without a pending request, closes without a response, or misses the write-active extra cycle. A stale or wrongly cleared pending latch shows on `req_pending_o` in the first cycle after the acknowledge drops. A lost last-transfer flag shows on `tend_o` in the first cycle of the window. Sweeping both sense modes, both write modes and both last-flag values exposes each of these within one transaction.

// File: rtl/dma_periph_hs_pkg.sv
package dma_periph_hs_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_DATA = 2'd1,
    HS_HOLD = 2'd2
  } hs_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_req_detect.sv
module hs_req_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  input  logic level_mode,
  input  logic idle,
  input  logic start,
  output logic pending,
  output logic req_rise
);
  logic req_d;
  logic pend_q;

  function automatic logic rise_of(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  assign req_rise = rise_of(req_s, req_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_d  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_d <= req_s;
      if (req_rise)   pend_q <= 1'b1;
      else if (start) pend_q <= 1'b0;
    end
  end

  assign pending = level_mode ? (req_s & idle) : pend_q;
endmodule

// File: rtl/hs_ack_ctrl.sv
module hs_ack_ctrl
  import dma_periph_hs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic aw_valid,
  input  logic b_valid,
  input  logic b_ready,
  input  logic wr_active,
  input  logic last,
  input  logic pending,
  output logic ack,
  output logic tend,
  output logic idle,
  output logic start,
  output logic bus_end,
  output logic in_hold
);
  hs_state_e state_q, state_d;
  logic      tend_q;

  function automatic hs_state_e step(input hs_state_e cur, input logic go,
                                     input logic done, input logic hold_mode);
    case (cur)
      HS_IDLE: return go ? HS_DATA : HS_IDLE;
      HS_DATA: return done ? (hold_mode ? HS_HOLD : HS_IDLE) : HS_DATA;
      default: return HS_IDLE;
    endcase
  endfunction

  assign idle    = (state_q == HS_IDLE);
  assign in_hold = (state_q == HS_HOLD);
  assign start   = idle & aw_valid & pending;
  assign bus_end = (state_q == HS_DATA) & b_valid & b_ready;
  assign state_d = step(state_q, start, bus_end, wr_active);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      tend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start)                  tend_q <= last;
      else if (state_d == HS_IDLE) tend_q <= 1'b0;
    end
  end

  assign ack  = ~idle;
  assign tend = tend_q;
endmodule

// File: rtl/dma_periph_hs.sv
module dma_periph_hs #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic level_sense_i,
  input  logic wr_active_i,
  input  logic aw_valid_i,
  input  logic b_valid_i,
  input  logic b_ready_i,
  input  logic last_i,
  output logic req_pending_o,
  output logic ack_o,
  output logic tend_o
);
  logic req_s;
  logic hs_idle;
  logic hs_start;
  logic hs_bus_end;
  logic hs_in_hold;
  logic hs_req_rise;

  hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (req_i),
    .q    (req_s)
  );

  hs_req_detect u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_s     (req_s),
    .level_mode(level_sense_i),
    .idle      (hs_idle),
    .start     (hs_start),
    .pending   (req_pending_o),
    .req_rise  (hs_req_rise)
  );

  hs_ack_ctrl u_ack (
    .clk      (clk),
    .rst_n    (rst_n),
    .aw_valid (aw_valid_i),
    .b_valid  (b_valid_i),
    .b_ready  (b_ready_i),
    .wr_active(wr_active_i),
    .last     (last_i),
    .pending  (req_pending_o),
    .ack      (ack_o),
    .tend     (tend_o),
    .idle     (hs_idle),
    .start    (hs_start),
    .bus_end  (hs_bus_end),
    .in_hold  (hs_in_hold)
  );
endmodule

// File: rtl/dma_periph_hs_chk.sv
module dma_periph_hs_chk (
  input logic clk,
  input logic rst_n,
  input logic level_sense_i,
  input logic wr_active_i,
  input logic aw_valid_i,
  input logic req_pending_o,
  input logic ack_o,
  input logic tend_o,
  input logic hs_bus_end,
  input logic hs_in_hold,
  input logic hs_req_rise
);
  AST_TEND_INSIDE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    tend_o |-> ack_o); // R9

  AST_ACK_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> ($past(aw_valid_i) && $past(req_pending_o))); // R4

  AST_ACK_FALL_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_bus_end && !wr_active_i) |=> !ack_o); // R5

  AST_ACK_WA_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_bus_end && wr_active_i) |=> ack_o); // R6

  AST_LEVEL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (level_sense_i && ack_o) |-> !req_pending_o); // R7

  AST_EDGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_o) && !level_sense_i && !$past(hs_req_rise)) |-> !req_pending_o); // R10

  AST_FALL_NEEDS_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> ($past(hs_bus_end) || $past(hs_in_hold))); // R11
endmodule

bind dma_periph_hs dma_periph_hs_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .level_sense_i(level_sense_i),
  .wr_active_i  (wr_active_i),
  .aw_valid_i   (aw_valid_i),
  .req_pending_o(req_pending_o),
  .ack_o        (ack_o),
  .tend_o       (tend_o),
  .hs_bus_end   (hs_bus_end),
  .hs_in_hold   (hs_in_hold),
  .hs_req_rise  (hs_req_rise)
);

// File: tb/dma_periph_hs_bench.sv
module dma_periph_hs_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, req, lvl, wa, awv, bv, br, last;
  logic pend, ack, tend;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_periph_hs u_dma_periph_hs (
    .clk(clk), .rst_n(rst_n), .req_i(req), .level_sense_i(lvl),
    .wr_active_i(wa), .aw_valid_i(awv), .b_valid_i(bv), .b_ready_i(br),
    .last_i(last), .req_pending_o(pend), .ack_o(ack), .tend_o(tend)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // One full transaction; req is raised here and dropped at the end.
  task automatic txn(input logic s_lvl, input logic s_wa, input logic s_last, input int stall);
    lvl = s_lvl; wa = s_wa;
    req = 1'b1;
    tick(2);
    chk("R3 level pending after two edges / R2 edge not yet", pend, s_lvl);
    tick(1);
    chk("R2/R3 pending after three edges", pend, 1'b1);
    awv = 1'b1; last = s_last;
    tick(1);
    awv = 1'b0; last = 1'b0;
    chk("R4 ack rises after start", ack, 1'b1);
    chk("R8 tend follows last flag", tend, s_last);
    chk("R7/R10 pending low during ack", pend, 1'b0);
    bv = 1'b1; br = 1'b0;
    for (int i = 0; i < stall; i++) begin
      tick(1);
      chk("R11 valid without ready keeps ack", ack, 1'b1);
      chk("R2 held request not retriggered", pend, 1'b0);
    end
    bv = 1'b0; br = 1'b1;
    tick(1);
    chk("R11 ready without valid keeps ack", ack, 1'b1);
    bv = 1'b1; br = 1'b1;
    tick(1);
    bv = 1'b0; br = 1'b0;
    if (s_wa) begin
      chk("R6 ack held extra cycle", ack, 1'b1);
      chk("R8 tend held with ack", tend, s_last);
      chk("R7 level still masked in hold", pend, 1'b0);
      tick(1);
    end
    chk("R5/R6 ack falls", ack, 1'b0);
    chk("R9 tend falls with ack", tend, 1'b0);
    chk("R7 level request seen once ack low / R2 no edge retrigger", pend, s_lvl);
    req = 1'b0;
    tick(3);
    chk("R3 pending follows low request", pend, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b1; lvl = 1'b1; wa = 1'b0;
    awv = 1'b1; bv = 1'b0; br = 1'b0; last = 1'b1;
    tick(4);
    chk("R1 ack in reset", ack, 1'b0);
    chk("R1 tend in reset", tend, 1'b0);
    chk("R1 pending in reset", pend, 1'b0);
    req = 1'b0; awv = 1'b0; last = 1'b0; lvl = 1'b0;
    rst_n = 1'b1;
    tick(1);
    chk("R1 ack after release", ack, 1'b0);
    chk("R1 pending after release", pend, 1'b0);

    awv = 1'b1;
    tick(1);
    awv = 1'b0;
    chk("R4 start ignored without request", ack, 1'b0);

    for (int m = 0; m < 8; m++)
      txn(m[0], m[1], m[2], m % 3);

    // R10: edge latched while ack is open
    lvl = 1'b0; wa = 1'b0;
    req = 1'b1;
    tick(3);
    chk("R2 edge pending", pend, 1'b1);
    awv = 1'b1;
    tick(1);
    awv = 1'b0;
    chk("R10 pending cleared at ack rise", pend, 1'b0);
    req = 1'b0;
    tick(3);
    req = 1'b1;
    tick(3);
    chk("R10 new edge latched during ack", pend, 1'b1);
    chk("R10 ack still open", ack, 1'b1);
    bv = 1'b1; br = 1'b1;
    tick(1);
    bv = 1'b0; br = 1'b0;
    chk("R5 ack low after response", ack, 1'b0);
    chk("R10 latched request reported after window", pend, 1'b1);
    awv = 1'b1;
    tick(1);
    awv = 1'b0;
    chk("R4 second start from latched edge", ack, 1'b1);
    chk("R8 tend low without last", tend, 1'b0);
    bv = 1'b1; br = 1'b1;
    tick(1);
    bv = 1'b0; br = 1'b0; req = 1'b0;
    chk("R5 second window closes", ack, 1'b0);
    chk("R10 no stale pending", pend, 1'b0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule